// File: doc/BRIEF.md
# Segmented Switch-Enable Front End for a Three-Channel Video Current DAC

This block is the digital half of a three-channel (red, green, blue) video current DAC. On every rising clock edge it accepts one sample per channel. It holds each sample in an input register and splits the sample into an upper field and a lower field.

The upper field is decoded into a thermometer code. Each bit of that code enables one equal-weight unit current source. The lower field passes straight through as binary-weighted enables. A second register bank sits just in front of the analog switches. It makes every enable change on one clock edge, which keeps output glitches small.

A parameter sets where the sample is split. A second parameter chooses the clock edge for the output bank. With the falling edge, total latency drops from two cycles to one and a half. The current sources, bias circuit, reference and switch pairs lie outside this block; it drives only their enable lines.

Top module: `seg_dac_front`

## Requirements
- R1: Each channel's sample is captured on the rising clock edge. Later input changes leave a captured value untouched until the next rising edge.
- R2: With an upper field of M = DATA_W - LSB_W bits, each channel has 2^M - 1 unit enables. Unit enable k (bit k of the unit bus) is high exactly when the upper field's unsigned value is greater than k. The high bits therefore always form a contiguous run starting at bit 0.
- R3: Bit i of a channel's binary enable bus equals bit i of the captured sample (i < LSB_W), so it carries weight 2^i. In the default setting the three binary lanes weigh 1, 2 and 4.
- R4: For every one of the 1024 10-bit codes, (number of high unit enables) x 2^LSB_W + (binary bus value) equals the sample that was captured.
- R5: When a channel's code does not decrease, no unit enable that was high goes low.
- R6: With FALL_OUT = 0, a sample driven before rising edge n appears on the enables just after rising edge n+1 (two-edge latency). The enables change only on rising edges.
- R7: With FALL_OUT = 1, a sample driven before rising edge n appears on the enables just after the falling edge that follows edge n (one and a half cycles of latency).
- R8: LSB_W selects the split. With DATA_W = 10 and LSB_W = 5 there are 31 unit enables, each weighing 32, and 5 binary lanes.
- R9: The three channels share the clock but are otherwise independent. Each channel's enables depend only on its own input, by the same rule.
- R10: A synchronous active-high reset clears both register banks. While reset is held, every enable is low. Afterwards the enables stay low until fresh data has passed through both banks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; input bank on rising edge, output bank on the edge set by FALL_OUT |
| rst | input | 1 | Synchronous active-high reset of both banks |
| r_code | input | DATA_W | Red channel sample |
| g_code | input | DATA_W | Green channel sample |
| b_code | input | DATA_W | Blue channel sample |
| r_unit | output | 2^(DATA_W-LSB_W)-1 | Red thermometer unit-source enables |
| r_bin | output | LSB_W | Red binary-weighted source enables |
| g_unit | output | 2^(DATA_W-LSB_W)-1 | Green thermometer unit-source enables |
| g_bin | output | LSB_W | Green binary-weighted source enables |
| b_unit | output | 2^(DATA_W-LSB_W)-1 | Blue thermometer unit-source enables |
| b_bin | output | LSB_W | Blue binary-weighted source enables |

## Verification
A fault in the input bank or the decoder shows up at the ports within one output-bank update. A wrong unit bus breaks the contiguous run or the weighted sum in the very next enable word. A wrong lower field corrupts the binary lanes at the same moment. A fault in the output bank's clock edge or reset shows as the enables changing half a cycle early or late, or as residual enables after reset. To catch these, the bench samples the rising-edge build and the falling-edge build side by side at fixed points within each cycle.

// File: rtl/seg_dac_front.sv
module seg_dac_front #(
  parameter int DATA_W   = 10,
  parameter int LSB_W    = 3,
  parameter bit FALL_OUT = 1'b0
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [DATA_W-1:0]                 r_code,
  input  logic [DATA_W-1:0]                 g_code,
  input  logic [DATA_W-1:0]                 b_code,
  output logic [(2**(DATA_W-LSB_W))-2:0]    r_unit,
  output logic [LSB_W-1:0]                  r_bin,
  output logic [(2**(DATA_W-LSB_W))-2:0]    g_unit,
  output logic [LSB_W-1:0]                  g_bin,
  output logic [(2**(DATA_W-LSB_W))-2:0]    b_unit,
  output logic [LSB_W-1:0]                  b_bin
);
  localparam int MSB_W = DATA_W - LSB_W;
  localparam int UNITS = (2**MSB_W) - 1;
  localparam int CH    = 3;

  logic [DATA_W-1:0] din   [CH];
  logic [UNITS-1:0]  out_u [CH];
  logic [LSB_W-1:0]  out_b [CH];

  assign din[0] = r_code;
  assign din[1] = g_code;
  assign din[2] = b_code;

  assign r_unit = out_u[0];
  assign r_bin  = out_b[0];
  assign g_unit = out_u[1];
  assign g_bin  = out_b[1];
  assign b_unit = out_u[2];
  assign b_bin  = out_b[2];

  logic [1:0] live;
  always_ff @(posedge clk) begin
    if (rst)              live <= 2'd0;
    else if (live != 2'd3) live <= live + 2'd1;
  end

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [DATA_W-1:0] cap;
    logic [UNITS-1:0]  dec;
    logic [UNITS-1:0]  ou;
    logic [LSB_W-1:0]  ob;
    int                wsum;

    always_ff @(posedge clk) begin
      if (rst) cap <= '0;
      else     cap <= din[c];
    end

    always_comb begin
      for (int k = 0; k < UNITS; k++)
        dec[k] = (int'(cap[DATA_W-1:LSB_W]) > k);
    end

    if (FALL_OUT) begin : g_fall
      always_ff @(negedge clk) begin
        if (rst) begin
          ou <= '0;
          ob <= '0;
        end else begin
          ou <= dec;
          ob <= cap[LSB_W-1:0];
        end
      end
    end else begin : g_rise
      always_ff @(posedge clk) begin
        if (rst) begin
          ou <= '0;
          ob <= '0;
        end else begin
          ou <= dec;
          ob <= cap[LSB_W-1:0];
        end
      end
    end

    assign out_u[c] = ou;
    assign out_b[c] = ob;
    assign wsum = ($countones(ou) * (2**LSB_W)) + int'(ob);

    // R2
    thermo_shape_chk: assert property (@(posedge clk) disable iff (rst)
      ((ou & (ou + 1'b1)) == '0));

    // R4
    if (FALL_OUT) begin : g_sum_f
      sum_match_chk: assert property (@(posedge clk) disable iff (rst)
        (live >= 2'd1) |-> (wsum == int'($past(din[c]))));
    end else begin : g_sum_r
      sum_match_chk: assert property (@(posedge clk) disable iff (rst)
        (live >= 2'd2) |-> (wsum == int'($past(din[c], 2))));
    end

    // R5
    monotone_chk: assert property (@(posedge clk) disable iff (rst)
      (live >= 2'd1 && wsum >= $past(wsum)) |-> (($past(ou) & ~ou) == '0));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
      (rst && $past(rst)) |-> (ou == '0 && ob == '0));
  end
endmodule

// File: tb/sim_seg_dac_front.sv
`timescale 1ns/1ps
module sim_seg_dac_front;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [9:0] rc = '0, gc = '0, bc = '0;
  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  logic [126:0] a_ru, a_gu, a_bu, f_ru, f_gu, f_bu;
  logic [2:0]   a_rb, a_gb, a_bb, f_rb, f_gb, f_bb;
  logic [30:0]  w_ru, w_gu, w_bu;
  logic [4:0]   w_rb, w_gb, w_bb;

  seg_dac_front #(.DATA_W(10), .LSB_W(3), .FALL_OUT(1'b0)) u0 (
    .clk(clk), .rst(rst), .r_code(rc), .g_code(gc), .b_code(bc),
    .r_unit(a_ru), .r_bin(a_rb), .g_unit(a_gu), .g_bin(a_gb), .b_unit(a_bu), .b_bin(a_bb));
  seg_dac_front #(.DATA_W(10), .LSB_W(3), .FALL_OUT(1'b1)) u1 (
    .clk(clk), .rst(rst), .r_code(rc), .g_code(gc), .b_code(bc),
    .r_unit(f_ru), .r_bin(f_rb), .g_unit(f_gu), .g_bin(f_gb), .b_unit(f_bu), .b_bin(f_bb));
  seg_dac_front #(.DATA_W(10), .LSB_W(5), .FALL_OUT(1'b0)) u2 (
    .clk(clk), .rst(rst), .r_code(rc), .g_code(gc), .b_code(bc),
    .r_unit(w_ru), .r_bin(w_rb), .g_unit(w_gu), .g_bin(w_gb), .b_unit(w_bu), .b_bin(w_bb));

  int  hc [3][3];
  bit  hr [3];

  function automatic logic [126:0] exp_u(int code, int lsbw);
    logic [126:0] v = '0;
    for (int k = 0; k < 127; k++) if ((code >> lsbw) > k) v[k] = 1'b1;
    return v;
  endfunction

  task automatic chk(string req, string who, int code, logic [126:0] u, logic [4:0] b, int lsbw);
    logic [126:0] xu = exp_u(code, lsbw);
    logic [4:0]   xb = 5'(code & ((1 << lsbw) - 1));
    total++;
    if (u !== xu || b !== xb) begin
      fails++;
      $display("FAIL %s %s: units=%h bin=%h expected units=%h bin=%h", req, who, u, b, xu, xb);
    end
  endtask

  task automatic chk_sum(string req, string who, int code, logic [126:0] u, logic [4:0] b, int lsbw);
    int s = $countones(u) * (1 << lsbw) + int'(b);
    total++;
    if (s != code) begin
      fails++;
      $display("FAIL %s %s: weighted sum=%0d expected %0d", req, who, s, code);
    end
  endtask

  task automatic step(int r, int g, int b, bit rs, string req);
    int ef [3];
    int er [3];
    @(posedge clk); #1;
    rst = rs; rc = 10'(r); gc = 10'(g); bc = 10'(b);
    for (int ch = 0; ch < 3; ch++) begin
      hc[2][ch] = hc[1][ch]; hc[1][ch] = hc[0][ch];
    end
    hc[0][0] = r; hc[0][1] = g; hc[0][2] = b;
    hr[2] = hr[1]; hr[1] = hr[0]; hr[0] = rs;
    #3;
    for (int ch = 0; ch < 3; ch++) begin
      ef[ch] = (hr[0] || hr[1]) ? 0 : hc[1][ch];
      er[ch] = (hr[1] || hr[2]) ? 0 : hc[2][ch];
    end
    chk(req, "rise r", er[0], a_ru, 5'(a_rb), 3);
    chk(req, "rise g", er[1], a_gu, 5'(a_gb), 3);
    chk(req, "rise b", er[2], a_bu, 5'(a_bb), 3);
    chk(req, "fall r", ef[0], f_ru, 5'(f_rb), 3);
    chk(req, "fall g", ef[1], f_gu, 5'(f_gb), 3);
    chk(req, "fall b", ef[2], f_bu, 5'(f_bb), 3);
    chk(req, "split55 r", er[0], 127'(w_ru), w_rb, 5);
    chk(req, "split55 g", er[1], 127'(w_gu), w_gb, 5);
    chk(req, "split55 b", er[2], 127'(w_bu), w_bb, 5);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 4; i++) step(1023, 512, 77, 1'b1, "R10 reset hold");
  endtask

  task automatic t_sweep;
    logic [126:0] prev = '0;
    for (int c = 0; c < 1026; c++) begin
      int cc = (c < 1024) ? c : 1023;
      step(cc, 1023 - cc, (cc * 37) % 1024, 1'b0, "R2 R3 R6 R7 R8 sweep");
      if (c >= 2) begin
        chk_sum("R4", "rise r", c - 2, a_ru, 5'(a_rb), 3);
        chk_sum("R4", "split55 r", c - 2, 127'(w_ru), w_rb, 5);
        total++;
        if ((prev & ~a_ru) != '0) begin
          fails++;
          $display("FAIL R5 rise r: units=%h dropped bits of %h expected none", a_ru, prev);
        end
        prev = a_ru;
      end
    end
  endtask

  task automatic t_channels;
    step(0, 1023, 8, 1'b0, "R9 channels");
    step(1023, 0, 7, 1'b0, "R9 channels");
    step(5, 640, 129, 1'b0, "R9 channels");
    step(127, 128, 1000, 1'b0, "R9 channels");
    step(127, 128, 1000, 1'b0, "R9 channels");
  endtask

  task automatic t_extremes;
    for (int i = 0; i < 6; i++) step((i % 2) ? 1023 : 0, (i % 2) ? 0 : 1023, 511 + (i % 2), 1'b0, "R2 R3 extremes");
    step(1, 1, 1, 1'b0, "R3 extremes");
    step(1, 1, 1, 1'b0, "R3 extremes");
  endtask

  task automatic t_midreset;
    step(300, 301, 302, 1'b0, "R10 before reset");
    step(600, 601, 602, 1'b0, "R10 before reset");
    step(900, 901, 902, 1'b1, "R10 reset pulse");
    step(400, 401, 402, 1'b0, "R10 after reset");
    step(450, 451, 452, 1'b0, "R10 after reset");
    step(450, 451, 452, 1'b0, "R10 after reset");
  endtask

  task automatic t_latency;
    step(100, 100, 100, 1'b0, "R6 R7 settle");
    step(100, 100, 100, 1'b0, "R6 R7 settle");
    step(100, 100, 100, 1'b0, "R6 R7 settle");
    @(posedge clk); #1;
    rc = 10'd900; gc = 10'd900; bc = 10'd900;
    @(posedge clk); #0.5;
    rc = 10'd5; gc = 10'd5; bc = 10'd5;
    #0.5;
    chk("R7 before falling edge", "fall r", 100, f_ru, 5'(f_rb), 3);
    chk("R6 after first edge", "rise r", 100, a_ru, 5'(a_rb), 3);
    #2.5;
    chk("R7 R1 after falling edge", "fall r", 900, f_ru, 5'(f_rb), 3);
    chk("R6 before second edge", "rise r", 100, a_ru, 5'(a_rb), 3);
    @(posedge clk); #1;
    chk("R6 R1 after second edge", "rise r", 900, a_ru, 5'(a_rb), 3);
    chk("R8 R1 after second edge", "split55 r", 900, 127'(w_ru), w_rb, 5);
    @(posedge clk); #1;
    for (int a = 0; a < 3; a++) begin
      for (int ch = 0; ch < 3; ch++) hc[a][ch] = 5;
      hr[a] = 1'b0;
    end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    total++;
    fails++;
    $display("FAIL watchdog: run still going, expected completion");
    finish_run();
  end

  initial begin
    for (int a = 0; a < 3; a++) begin
      for (int ch = 0; ch < 3; ch++) hc[a][ch] = 0;
      hr[a] = 1'b1;
    end
    t_reset();
    t_sweep();
    t_channels();
    t_extremes();
    t_midreset();
    t_latency();
    t_channels();
    finish_run();
  end
endmodule